// File: doc/BRIEF.md
# Signed Binary to ASCII Decimal Converter

This block converts a two's-complement value that lies between -999 and +999 into four ASCII characters. The characters are a sign followed by the hundreds, tens and ones digits. A pulse on `start` captures the input. The block then extracts the digits by trial subtraction, one subtraction per clock. It subtracts 100 until the remainder would turn negative, then subtracts 10 in the same way. Each digit register starts at the ASCII code of '0' and counts up once for every subtraction that succeeds. The ones digit is the remainder that is left, offset into ASCII.

`busy` is high while a conversion runs. A single-cycle `done` pulse marks the cycle in which the four character outputs take their new values together. The outputs then hold those values until the next conversion completes. A caller pulses `start` when `busy` is low and reads the four characters when it sees `done`.

Top module: `sbin2dec_ascii`

## Requirements
- R1: After reset, `busy` and `done` are 0 and all four character outputs are 8'h00.
- R2: On completion, `sign_char` is 8'h2B ('+') for an input of zero or more and 8'h2D ('-') for a negative input.
- R3: A negative input is turned into its magnitude by two's complement (invert, add one), so the digits show the absolute value.
- R4: `hund_char` equals 8'h30 plus the magnitude divided by 100.
- R5: `tens_char` equals 8'h30 plus the tens digit of the magnitude (the remainder after the hundreds, divided by 10).
- R6: `ones_char` equals 8'h30 plus the magnitude modulo 10.
- R7: The result is given on four separate ports in reading order: sign, hundreds, tens, ones.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running conversion finishes with its original value and its original latency.
- R9: `done` lasts exactly one cycle. `busy` is high from the edge that samples `start` until the edge that raises `done`, and it is never high at the same time as `done`.
- R10: `done` rises H+T+3 clock edges after the edge that samples `start`, where H and T are the hundreds and tens digits of the magnitude. For ±999 this is 21 edges.
- R11: The character outputs change only on the edge that raises `done`, and they stay stable at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion of `value_in` (sampled when idle) |
| value_in | input | 16 | Two's-complement value, -999..+999 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: new characters are valid |
| sign_char | output | 8 | ASCII sign |
| hund_char | output | 8 | ASCII hundreds digit |
| tens_char | output | 8 | ASCII tens digit |
| ones_char | output | 8 | ASCII ones digit |

## Verification
If the subtraction loop miscounts or fails to restore the last trial, a digit comes out shifted by one or jumps past '9'. Either fault shows in the characters presented with the very next `done` pulse. If a phase exits too early or too late, the digits are wrong and `done` arrives on a cycle other than H+T+3, so the bench measures the latency of every conversion exactly. If the controller accepts a `start` in the middle of a conversion, the result and the timing of the first value are corrupted in that same conversion.

// File: rtl/b2a_pkg.sv
package b2a_pkg;

   localparam int unsigned CHR_W = 8;

   localparam logic [CHR_W-1:0] ASC_ZERO  = 8'h30;
   localparam logic [CHR_W-1:0] ASC_PLUS  = 8'h2B;
   localparam logic [CHR_W-1:0] ASC_MINUS = 8'h2D;

   localparam int unsigned N_STEPS = 2;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_HUND = 2'd1,
      PH_TENS = 2'd2,
      PH_ONES = 2'd3
   } phase_t;

   function automatic int unsigned step_divisor(input int unsigned idx);
      int unsigned d;
      d = 1;
      for (int unsigned i = 0; i < N_STEPS - idx; i++) d = d * 10;
      return d;
   endfunction

endpackage

// File: rtl/b2a_sign_split.sv
module b2a_sign_split
   import b2a_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] value_i,
   output logic [DATA_W-1:0] mag_o,
   output logic [CHR_W-1:0]  sign_o
);

   logic neg;

   always_comb begin
      neg    = value_i[DATA_W-1];
      mag_o  = neg ? (~value_i + DATA_W'(1)) : value_i;
      sign_o = neg ? ASC_MINUS : ASC_PLUS;
   end

   always_comb begin
      if (neg)
         assert_mag_positive_R3: assert (mag_o[DATA_W-1] == 1'b0 || value_i == {1'b1, {(DATA_W-1){1'b0}}})
            else $error("magnitude of negative input is still negative");
   end

endmodule

// File: rtl/b2a_digit_step.sv
module b2a_digit_step
   import b2a_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned DIVISOR = 100
) (
   input  logic [DATA_W-1:0] rem_i,
   input  logic [CHR_W-1:0]  digit_i,
   output logic [DATA_W-1:0] rem_o,
   output logic [CHR_W-1:0]  digit_o,
   output logic              take_o
);

   logic [DATA_W:0] trial;

   always_comb begin
      trial   = {1'b0, rem_i} - (DATA_W+1)'(DIVISOR);
      take_o  = ~trial[DATA_W];
      rem_o   = take_o ? trial[DATA_W-1:0] : rem_i;
      digit_o = take_o ? digit_i + CHR_W'(1) : digit_i;
   end

endmodule

// File: rtl/sbin2dec_ascii.sv
module sbin2dec_ascii
   import b2a_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned MAX_MAG = 999
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] value_in,
   output logic              busy,
   output logic              done,
   output logic [7:0]        sign_char,
   output logic [7:0]        hund_char,
   output logic [7:0]        tens_char,
   output logic [7:0]        ones_char
);

   localparam int unsigned MAX_H   = MAX_MAG / 100;
   localparam int unsigned MAX_T   = (MAX_MAG % 100) / 10;
   localparam int unsigned MAX_LAT = MAX_H + MAX_T + 3;
   localparam int unsigned LAT_W   = $clog2(MAX_LAT + 2);

   generate
      if (DATA_W < 11) begin : g_bad_width
         $error("DATA_W must hold +/-%0d", MAX_MAG);
      end
      if (MAX_MAG > 999) begin : g_bad_range
         $error("MAX_MAG above three digits");
      end
   endgenerate

   phase_t              phase;
   logic [DATA_W-1:0]   rem_q;
   logic [CHR_W-1:0]    sign_q;
   logic [CHR_W-1:0]    work_dig [N_STEPS];
   logic [DATA_W-1:0]   step_rem [N_STEPS];
   logic [CHR_W-1:0]    step_dig [N_STEPS];
   logic                step_take[N_STEPS];
   logic [DATA_W-1:0]   mag_in;
   logic [CHR_W-1:0]    sign_in;
   logic [DATA_W-1:0]   ones_full;

   b2a_sign_split #(.DATA_W(DATA_W)) u_sign (
      .value_i(value_in),
      .mag_o  (mag_in),
      .sign_o (sign_in)
   );

   genvar g;
   generate
      for (g = 0; g < N_STEPS; g++) begin : g_step
         b2a_digit_step #(
            .DATA_W (DATA_W),
            .DIVISOR(step_divisor(g))
         ) u_step (
            .rem_i  (rem_q),
            .digit_i(work_dig[g]),
            .rem_o  (step_rem[g]),
            .digit_o(step_dig[g]),
            .take_o (step_take[g])
         );
      end
   endgenerate

   assign ones_full = DATA_W'(ASC_ZERO) + rem_q;
   assign busy      = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         rem_q     <= '0;
         sign_q    <= '0;
         for (int i = 0; i < N_STEPS; i++) work_dig[i] <= '0;
         done      <= 1'b0;
         sign_char <= '0;
         hund_char <= '0;
         tens_char <= '0;
         ones_char <= '0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start) begin
                  rem_q  <= mag_in;
                  sign_q <= sign_in;
                  for (int i = 0; i < N_STEPS; i++) work_dig[i] <= ASC_ZERO;
                  phase  <= PH_HUND;
               end
            end
            PH_HUND: begin
               if (step_take[0]) begin
                  rem_q       <= step_rem[0];
                  work_dig[0] <= step_dig[0];
               end else begin
                  phase <= PH_TENS;
               end
            end
            PH_TENS: begin
               if (step_take[1]) begin
                  rem_q       <= step_rem[1];
                  work_dig[1] <= step_dig[1];
               end else begin
                  phase <= PH_ONES;
               end
            end
            PH_ONES: begin
               sign_char <= sign_q;
               hund_char <= work_dig[0];
               tens_char <= work_dig[1];
               ones_char <= ones_full[CHR_W-1:0];
               done      <= 1'b1;
               phase     <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   logic [LAT_W-1:0] lat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lat_cnt <= '0;
      else if (busy) lat_cnt <= lat_cnt + LAT_W'(1);
      else           lat_cnt <= '0;
   end

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && phase == PH_HUND) |=> (phase != PH_IDLE));

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (lat_cnt <= LAT_W'(MAX_LAT - 1)));

   assert_out_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(sign_char) && $stable(hund_char) && $stable(tens_char) && $stable(ones_char)));

   assert_sign_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sign_char == ASC_PLUS || sign_char == ASC_MINUS));

   assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (hund_char >= 8'h30 && hund_char <= 8'h39 && tens_char >= 8'h30 && tens_char <= 8'h39));

   assert_ones_rem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ONES) |-> (rem_q < DATA_W'(10)));

endmodule

// File: tb/tb_sbin2dec_ascii.sv
`timescale 1ns/1ps
module tb_sbin2dec_ascii;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] value_in = '0;
   logic        busy, done;
   logic [7:0]  sign_char, hund_char, tens_char, ones_char;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   sbin2dec_ascii dut (
      .clk(clk), .rst_n(rst_n), .start(start), .value_in(value_in),
      .busy(busy), .done(done),
      .sign_char(sign_char), .hund_char(hund_char),
      .tens_char(tens_char), .ones_char(ones_char)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_chars(input int v);
      int m;
      m = (v < 0) ? -v : v;
      return {(v < 0) ? 8'h2D : 8'h2B, 8'(8'h30 + m / 100),
              8'(8'h30 + (m % 100) / 10), 8'(8'h30 + m % 10)};
   endfunction

   function automatic int exp_lat(input int v);
      int m;
      m = (v < 0) ? -v : v;
      return m / 100 + (m % 100) / 10 + 3;
   endfunction

   task automatic run(input int v, input bit interfere, input int v2);
      int cnt;
      bit busy_ok, stab_ok;
      logic [31:0] prev, cur;
      busy_ok = 1'b1;
      stab_ok = 1'b1;
      @(negedge clk);
      prev = {sign_char, hund_char, tens_char, ones_char};
      value_in = 16'(v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 64) begin
         if (!busy) busy_ok = 1'b0;
         if ({sign_char, hund_char, tens_char, ones_char} !== prev) stab_ok = 1'b0;
         if (interfere && cnt == 2) begin
            start = 1'b1;
            value_in = 16'(v2);
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      cur = {sign_char, hund_char, tens_char, ones_char};
      chk("R9 busy held during conversion", 32'(busy_ok), 32'd1);
      chk("R11 outputs stable before done", 32'(stab_ok), 32'd1);
      chk("R9 busy low with done", 32'(busy), 32'd0);
      chk(interfere ? "R10/R8 latency with ignored start" : "R10 latency", 32'(cnt - 1), 32'(exp_lat(v)));
      chk(interfere ? "R8 result after ignored start" : "R2 R3 R4 R5 R6 R7 characters", cur, exp_chars(v));
      @(negedge clk);
      chk("R9 done single cycle", 32'(done), 32'd0);
      chk("R11 outputs held after done", {sign_char, hund_char, tens_char, ones_char}, cur);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      int r;
      r = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      chk("R1 reset busy", 32'(busy), 32'd0);
      chk("R1 reset done", 32'(done), 32'd0);
      chk("R1 reset chars", {sign_char, hund_char, tens_char, ones_char}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", 32'(busy), 32'd0);

      run(0, 0, 0);
      run(999, 0, 0);
      run(-999, 0, 0);
      run(-1, 0, 0);
      run(1, 0, 0);
      run(100, 0, 0);
      run(-100, 0, 0);
      run(10, 0, 0);
      run(90, 0, 0);
      run(509, 0, 0);
      run(-450, 0, 0);
      run(999, 1, -123);
      run(0, 1, 777);
      run(-58, 1, 5);

      for (int i = 0; i < 60; i++) begin
         int v;
         v = int'($urandom_range(1998)) - 999;
         run(v, (i % 7) == 3, int'($urandom_range(1998)) - 999);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule